// File: doc/BRIEF.md
# Stream DMA Source with Early Termination

This block is the stream-facing front end of a DMA engine. It receives a transfer as a sequence of segment requests. Each request carries a programmed beat count and a flag that marks the final segment of the transfer. It then moves the matching beats from an incoming ready/valid stream to an outgoing stream. Every burst is tagged with a small wrap-around burst ID. When a burst closes, the block emits a descriptor for the destination side with the number of beats that actually moved and an end-of-transfer flag. It also emits a completion entry.

The producer may end a transfer early by raising its last-beat marker inside a segment that is not the final one. The block then closes that burst with the short count and flags end-of-transfer. It swallows the rest of the transfer's segment requests without sending descriptors for them, but still reports a completion for each one. It also winds the burst ID back, so the next transfer continues right after the terminating burst, even if an ID had already been handed to a prefetched segment.

A one-entry holding slot takes the next segment request while the current burst is still streaming. An explicit two-mode state machine (run, drain) governs the slot and the ID counter.

Top module: `sdma_stream_src`

## Requirements
- R1: After reset, seg_ready is 1, s_ready is 0, and dsc_valid and cpl_valid are 0.
- R2: For every burst that moves data, one descriptor and one completion (cpl_skip=0) appear together, one cycle after the edge that accepts the burst's last beat. Both carry the same ID and a beat count equal to the beats actually accepted.
- R3: A burst closes when its accepted beats reach the programmed seg_len (1 to 2^LEN_W-1) or when a beat with s_last=1 is accepted, whichever comes first.
- R4: Bursts receive consecutive IDs, modulo 2^ID_W, in the order their segments are accepted. The first ID after reset is 0.
- R5: A beat with s_last=1 inside a non-final segment terminates the transfer. No descriptor is produced for any remaining segment of that transfer.
- R6: Each discarded segment produces exactly one completion with cpl_skip=1, cpl_beats=0 and cpl_id equal to the ID of the terminating burst. These completions come in segment order and never share a cycle with a descriptor.
- R7: After an early termination, the next transfer's first burst gets the terminating burst's ID plus one (mod 2^ID_W), even if an ID had already been handed to a prefetched segment.
- R8: dsc_eot is 1 exactly for the burst of a final segment (seg_last=1) and for a burst closed by s_last.
- R9: s_ready is 1 only while a burst is active and m_ready is 1. Accepted beats appear on m_data unchanged and in order, with m_valid.
- R10: s_last inside the final segment closes it with the short count and dsc_eot=1. No completion with cpl_skip=1 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_valid | input | 1 | Segment request valid |
| seg_ready | output | 1 | Segment request accepted |
| seg_len | input | LEN_W | Programmed beats of the segment |
| seg_last | input | 1 | Segment is the final one of its transfer |
| s_valid | input | 1 | Input stream beat valid |
| s_ready | output | 1 | Input stream beat accepted |
| s_data | input | DATA_W | Input stream data |
| s_last | input | 1 | Producer ends the transfer with this beat |
| m_valid | output | 1 | Output stream beat valid |
| m_ready | input | 1 | Destination accepts output beat |
| m_data | output | DATA_W | Output stream data |
| dsc_valid | output | 1 | Burst descriptor pulse |
| dsc_id | output | ID_W | Burst ID of the descriptor |
| dsc_beats | output | LEN_W | Beats actually moved in the burst |
| dsc_eot | output | 1 | End-of-transfer toward the destination |
| cpl_valid | output | 1 | Completion pulse |
| cpl_id | output | ID_W | Burst ID of the completion |
| cpl_beats | output | LEN_W | Beats moved (0 for a discarded segment) |
| cpl_skip | output | 1 | Completion belongs to a discarded segment |

## Verification
Descriptors and data-carrying completions are due one cycle after the edge that accepts a burst's last beat. Discard completions come one per cycle, beginning two cycles after the terminating edge, with one more cycle of delay for each segment that still has to be fetched. Every report is a registered one-cycle pulse. The bench samples the outputs once per cycle, a quarter period before the rising edge, so each pulse is logged exactly once and in order. Each scenario compares the full descriptor, completion and data logs only after a settle window longer than the slowest of these latencies.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    typedef enum logic {
        MODE_RUN   = 1'b0,
        MODE_DRAIN = 1'b1
    } sdma_mode_e;

    typedef enum logic [1:0] {
        RPT_NONE = 2'd0,
        RPT_BURST = 2'd1,
        RPT_SKIP = 2'd2
    } sdma_rpt_e;

    function automatic sdma_rpt_e rpt_kind(input logic burst_end, input logic skip_evt);
        if (burst_end)
            return RPT_BURST;
        else if (skip_evt)
            return RPT_SKIP;
        return RPT_NONE;
    endfunction

endpackage

// File: rtl/sdma_beat_ctr.sv
module sdma_beat_ctr #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cur_vld,
    input  logic [LEN_W-1:0] cur_len,
    input  logic             cur_last,
    input  logic             beat,
    input  logic             s_last,
    output logic             burst_end,
    output logic             term,
    output logic [LEN_W-1:0] beats_done
);

    logic [LEN_W-1:0] cnt;

    assign beats_done = cnt + 1'b1;
    assign burst_end  = beat && (s_last || (beats_done == cur_len));
    assign term       = beat && s_last && !cur_last;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (burst_end)
            cnt <= '0;
        else if (beat)
            cnt <= cnt + 1'b1;
    end

    // R3: the running count never reaches the programmed length while active
    a_r3_cnt_below_len: assert property (@(posedge clk) disable iff (rst)
        cur_vld |-> (cnt < cur_len));

endmodule

// File: rtl/sdma_seg_fsm.sv
module sdma_seg_fsm
    import sdma_pkg::*;
#(
    parameter int LEN_W = 4,
    parameter int ID_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seg_valid,
    output logic             seg_ready,
    input  logic [LEN_W-1:0] seg_len,
    input  logic             seg_last,
    input  logic             burst_end,
    input  logic             term,
    output logic             cur_vld,
    output logic [ID_W-1:0]  cur_id,
    output logic [LEN_W-1:0] cur_len,
    output logic             cur_last,
    output sdma_mode_e       mode,
    output logic             skip_evt,
    output logic [ID_W-1:0]  hold_id
);

    logic             nxt_vld;
    logic [ID_W-1:0]  nxt_id;
    logic [LEN_W-1:0] nxt_len;
    logic             nxt_last;
    logic [ID_W-1:0]  id_ctr;
    logic             seg_take;

    assign seg_ready = !nxt_vld;
    assign seg_take  = seg_valid && seg_ready;
    assign skip_evt  = (mode == MODE_DRAIN) && nxt_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_RUN;
            cur_vld  <= 1'b0;
            cur_id   <= '0;
            cur_len  <= '0;
            cur_last <= 1'b0;
            nxt_vld  <= 1'b0;
            nxt_id   <= '0;
            nxt_len  <= '0;
            nxt_last <= 1'b0;
            id_ctr   <= '0;
            hold_id  <= '0;
        end else begin
            if (term)
                id_ctr <= cur_id + 1'b1;
            else if (seg_take && (mode == MODE_RUN))
                id_ctr <= id_ctr + 1'b1;

            case (mode)
                MODE_RUN: begin
                    if (burst_end) begin
                        cur_vld <= 1'b0;
                    end else if (!cur_vld && nxt_vld) begin
                        cur_vld  <= 1'b1;
                        cur_id   <= nxt_id;
                        cur_len  <= nxt_len;
                        cur_last <= nxt_last;
                        nxt_vld  <= 1'b0;
                    end
                    if (term) begin
                        mode    <= MODE_DRAIN;
                        hold_id <= cur_id;
                    end
                end
                MODE_DRAIN: begin
                    if (nxt_vld) begin
                        nxt_vld <= 1'b0;
                        if (nxt_last)
                            mode <= MODE_RUN;
                    end
                end
                default: mode <= MODE_RUN;
            endcase

            if (seg_take) begin
                nxt_vld  <= 1'b1;
                nxt_id   <= id_ctr;
                nxt_len  <= seg_len;
                nxt_last <= seg_last;
            end
        end
    end

    // R7: a terminating beat winds the ID counter back to just after its burst
    a_r7_id_rewind: assert property (@(posedge clk) disable iff (rst)
        term |=> (id_ctr == $past(cur_id) + 1'b1));

    // R5: no burst becomes active while segments are being discarded
    a_r5_no_burst_in_drain: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DRAIN) |-> !cur_vld);

endmodule

// File: rtl/sdma_report.sv
module sdma_report
    import sdma_pkg::*;
#(
    parameter int LEN_W = 4,
    parameter int ID_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             burst_end,
    input  logic             fin_eot,
    input  logic [ID_W-1:0]  fin_id,
    input  logic [LEN_W-1:0] fin_beats,
    input  logic             skip_evt,
    input  logic [ID_W-1:0]  hold_id,
    output logic             dsc_valid,
    output logic [ID_W-1:0]  dsc_id,
    output logic [LEN_W-1:0] dsc_beats,
    output logic             dsc_eot,
    output logic             cpl_valid,
    output logic [ID_W-1:0]  cpl_id,
    output logic [LEN_W-1:0] cpl_beats,
    output logic             cpl_skip
);

    sdma_rpt_e kind;
    assign kind = rpt_kind(burst_end, skip_evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            dsc_valid <= 1'b0;
            dsc_id    <= '0;
            dsc_beats <= '0;
            dsc_eot   <= 1'b0;
            cpl_valid <= 1'b0;
            cpl_id    <= '0;
            cpl_beats <= '0;
            cpl_skip  <= 1'b0;
        end else begin
            dsc_valid <= (kind == RPT_BURST);
            cpl_valid <= (kind != RPT_NONE);
            case (kind)
                RPT_BURST: begin
                    dsc_id    <= fin_id;
                    dsc_beats <= fin_beats;
                    dsc_eot   <= fin_eot;
                    cpl_id    <= fin_id;
                    cpl_beats <= fin_beats;
                    cpl_skip  <= 1'b0;
                end
                RPT_SKIP: begin
                    cpl_id    <= hold_id;
                    cpl_beats <= '0;
                    cpl_skip  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R2: a descriptor always reports at least one moved beat
    a_r2_dsc_nonzero: assert property (@(posedge clk) disable iff (rst)
        dsc_valid |-> (dsc_beats != '0));

    // R6: a discard completion never coincides with a descriptor
    a_r6_skip_alone: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && cpl_skip) |-> !dsc_valid);

endmodule

// File: rtl/sdma_stream_src.sv
module sdma_stream_src
    import sdma_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4,
    parameter int ID_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seg_valid,
    output logic              seg_ready,
    input  logic [LEN_W-1:0]  seg_len,
    input  logic              seg_last,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              dsc_valid,
    output logic [ID_W-1:0]   dsc_id,
    output logic [LEN_W-1:0]  dsc_beats,
    output logic              dsc_eot,
    output logic              cpl_valid,
    output logic [ID_W-1:0]   cpl_id,
    output logic [LEN_W-1:0]  cpl_beats,
    output logic              cpl_skip
);

    logic             cur_vld;
    logic [ID_W-1:0]  cur_id;
    logic [LEN_W-1:0] cur_len;
    logic             cur_last;
    sdma_mode_e       mode;
    logic             skip_evt;
    logic [ID_W-1:0]  hold_id;
    logic             burst_end;
    logic             term;
    logic [LEN_W-1:0] beats_done;
    logic             run_ok;
    logic             beat;

    assign run_ok  = cur_vld && (mode == MODE_RUN);
    assign s_ready = run_ok && m_ready;
    assign m_valid = s_valid && run_ok;
    assign m_data  = s_data;
    assign beat    = s_valid && s_ready;

    sdma_seg_fsm #(.LEN_W(LEN_W), .ID_W(ID_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .seg_valid (seg_valid),
        .seg_ready (seg_ready),
        .seg_len   (seg_len),
        .seg_last  (seg_last),
        .burst_end (burst_end),
        .term      (term),
        .cur_vld   (cur_vld),
        .cur_id    (cur_id),
        .cur_len   (cur_len),
        .cur_last  (cur_last),
        .mode      (mode),
        .skip_evt  (skip_evt),
        .hold_id   (hold_id)
    );

    sdma_beat_ctr #(.LEN_W(LEN_W)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .cur_vld    (cur_vld),
        .cur_len    (cur_len),
        .cur_last   (cur_last),
        .beat       (beat),
        .s_last     (s_last),
        .burst_end  (burst_end),
        .term       (term),
        .beats_done (beats_done)
    );

    sdma_report #(.LEN_W(LEN_W), .ID_W(ID_W)) u_rpt (
        .clk       (clk),
        .rst       (rst),
        .burst_end (burst_end),
        .fin_eot   (cur_last || s_last),
        .fin_id    (cur_id),
        .fin_beats (beats_done),
        .skip_evt  (skip_evt),
        .hold_id   (hold_id),
        .dsc_valid (dsc_valid),
        .dsc_id    (dsc_id),
        .dsc_beats (dsc_beats),
        .dsc_eot   (dsc_eot),
        .cpl_valid (cpl_valid),
        .cpl_id    (cpl_id),
        .cpl_beats (cpl_beats),
        .cpl_skip  (cpl_skip)
    );

    // R5: descriptors toward the destination stay blocked while draining
    a_r5_drain_blocks_dsc: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DRAIN) |=> !dsc_valid);

    // R9: no input beat is taken unless the destination takes it
    a_r9_ready_follows_dest: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (m_ready && m_valid == s_valid));

endmodule

// File: tb/test_sdma_stream_src.sv
module test_sdma_stream_src;
    localparam int CLK_P  = 10;
    localparam int MON_D  = CLK_P / 4;
    localparam int DATA_W = 16;
    localparam int LEN_W  = 4;
    localparam int ID_W   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic seg_valid = 1'b0, seg_last = 1'b0;
    logic [LEN_W-1:0] seg_len = '0;
    logic s_valid = 1'b0, s_last = 1'b0;
    logic [DATA_W-1:0] s_data = '0;
    logic m_ready = 1'b1;
    logic seg_ready, s_ready, m_valid;
    logic [DATA_W-1:0] m_data;
    logic dsc_valid, dsc_eot, cpl_valid, cpl_skip;
    logic [ID_W-1:0] dsc_id, cpl_id;
    logic [LEN_W-1:0] dsc_beats, cpl_beats;

    int nchk = 0, nfail = 0;
    bit finished = 0;
    int sl[16];
    int d_id[32], d_b[32], d_e[32], c_id[32], c_b[32], c_s[32], m_dat[64];
    int nd = 0, nc = 0, nm = 0;

    always #(CLK_P/2) clk = ~clk;

    sdma_stream_src #(.DATA_W(DATA_W), .LEN_W(LEN_W), .ID_W(ID_W)) i_sdma_stream_src (
        .clk(clk), .rst(rst),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_len(seg_len), .seg_last(seg_last),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .dsc_valid(dsc_valid), .dsc_id(dsc_id), .dsc_beats(dsc_beats), .dsc_eot(dsc_eot),
        .cpl_valid(cpl_valid), .cpl_id(cpl_id), .cpl_beats(cpl_beats), .cpl_skip(cpl_skip)
    );

    always @(negedge clk) begin
        #(MON_D);
        if (!rst) begin
            if (dsc_valid && nd < 32) begin
                d_id[nd] = dsc_id; d_b[nd] = dsc_beats; d_e[nd] = dsc_eot; nd++;
            end
            if (cpl_valid && nc < 32) begin
                c_id[nc] = cpl_id; c_b[nc] = cpl_beats; c_s[nc] = cpl_skip; nc++;
            end
            if (m_valid && m_ready && nm < 64) begin
                m_dat[nm] = m_data; nm++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic exp_d(input int k, input int id, input int b, input int e, input string tag);
        chk(d_id[k] == id, {tag, " dsc id"}, d_id[k], id);
        chk(d_b[k] == b, {tag, " dsc beats"}, d_b[k], b);
        chk(d_e[k] == e, {tag, " R8 dsc eot"}, d_e[k], e);
    endtask

    task automatic exp_c(input int k, input int id, input int b, input int s, input string tag);
        chk(c_id[k] == id, {tag, " cpl id"}, c_id[k], id);
        chk(c_b[k] == b, {tag, " cpl beats"}, c_b[k], b);
        chk(c_s[k] == s, {tag, " cpl skip"}, c_s[k], s);
    endtask

    task automatic clear_logs();
        nd = 0; nc = 0; nm = 0;
    endtask

    task automatic feed_segs(input int n);
        bit ok;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            seg_valid = 1'b1;
            seg_len   = LEN_W'(sl[i]);
            seg_last  = (i == n - 1);
            forever begin
                #1 ok = seg_ready;
                @(negedge clk);
                if (ok) break;
            end
        end
        seg_valid = 1'b0;
        seg_last  = 1'b0;
    endtask

    task automatic feed_stream(input int n, input int last_at, input int base, input bit bp);
        bit ok;
        @(negedge clk);
        for (int k = 1; k <= n; k++) begin
            s_valid = 1'b1;
            s_data  = DATA_W'(base + k);
            s_last  = (k == last_at);
            forever begin
                if (bp) m_ready = ~m_ready;
                #1 ok = s_ready;
                @(negedge clk);
                if (ok) break;
            end
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
        m_ready = 1'b1;
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        #(MON_D);
        chk(seg_ready == 1'b1, "R1 seg_ready", seg_ready, 1);
        chk(s_ready == 1'b0, "R1 s_ready", s_ready, 0);
        chk(dsc_valid == 1'b0, "R1 dsc_valid", dsc_valid, 0);
        chk(cpl_valid == 1'b0, "R1 cpl_valid", cpl_valid, 0);
    endtask

    task automatic t_exact_end();
        clear_logs();
        sl[0] = 4; sl[1] = 4; sl[2] = 3;
        fork
            feed_segs(3);
            feed_stream(11, 11, 100, 1'b1);
        join
        settle();
        chk(nd == 3, "R3 burst count", nd, 3);
        exp_d(0, 0, 4, 0, "R4 R3 b0");
        exp_d(1, 1, 4, 0, "R4 R3 b1");
        exp_d(2, 2, 3, 1, "R4 R3 b2");
        chk(nc == 3, "R2 cpl count", nc, 3);
        exp_c(0, 0, 4, 0, "R2 c0");
        exp_c(1, 1, 4, 0, "R2 c1");
        exp_c(2, 2, 3, 0, "R2 c2");
        chk(nm == 11, "R9 beat count", nm, 11);
        for (int i = 0; i < 11; i++)
            chk(m_dat[i] == 101 + i, "R9 data", m_dat[i], 101 + i);
    endtask

    task automatic t_mid_term();
        clear_logs();
        sl[0] = 4; sl[1] = 4; sl[2] = 4;
        fork
            feed_segs(3);
            feed_stream(6, 6, 200, 1'b0);
        join
        settle();
        chk(nd == 2, "R5 dsc count", nd, 2);
        exp_d(0, 3, 4, 0, "R4 m0");
        exp_d(1, 4, 2, 1, "R2 m1");
        chk(nc == 3, "R6 cpl count", nc, 3);
        exp_c(0, 3, 4, 0, "R2 mc0");
        exp_c(1, 4, 2, 0, "R2 mc1");
        exp_c(2, 4, 0, 1, "R6 mc2");
    endtask

    task automatic t_after_rewind();
        clear_logs();
        sl[0] = 2;
        fork
            feed_segs(1);
            feed_stream(2, 2, 300, 1'b0);
        join
        settle();
        chk(nd == 1, "R7 dsc count", nd, 1);
        exp_d(0, 5, 2, 1, "R7 rewound id");
    endtask

    task automatic t_first_term();
        clear_logs();
        sl[0] = 3; sl[1] = 3; sl[2] = 3; sl[3] = 3;
        fork
            feed_segs(4);
            feed_stream(2, 2, 400, 1'b0);
        join
        settle();
        chk(nd == 1, "R5 dsc count", nd, 1);
        exp_d(0, 6, 2, 1, "R2 f0");
        chk(nc == 4, "R6 cpl count", nc, 4);
        exp_c(0, 6, 2, 0, "R2 fc0");
        for (int i = 1; i < 4; i++)
            exp_c(i, 6, 0, 1, "R6 fc skip");
    endtask

    task automatic t_final_short();
        clear_logs();
        sl[0] = 3; sl[1] = 3;
        fork
            feed_segs(2);
            feed_stream(5, 5, 500, 1'b0);
        join
        settle();
        chk(nd == 2, "R10 dsc count", nd, 2);
        exp_d(0, 7, 3, 0, "R7 s0");
        exp_d(1, 0, 2, 1, "R10 R4 wrap s1");
        chk(nc == 2, "R10 no skip cpl", nc, 2);
        exp_c(1, 0, 2, 0, "R10 sc1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_exact_end();
        t_mid_term();
        t_after_rewind();
        t_first_term();
        t_final_short();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule